// File: doc/BRIEF.md
# Streaming 4x4 Integer Block Transform

This block computes the unscaled two-dimensional forward integer transform Y = K·B·Kᵀ of 4x4 blocks of unsigned samples. The kernel K has the rows [1 1 1 1], [2 1 -1 -2], [1 -1 -1 1] and [1 -2 2 -1]. Samples arrive one per accepted transfer, column by column. Within a column they arrive from row 0 to row 3. Coefficients leave one per accepted transfer in row-major order, Y[0][0] first. Any per-coefficient scaling is left to the consumer.

The block has a single 4-point butterfly. It alternates between the column pass and the row pass every four pipeline steps. Column results go into a 4x4 transposition register file. That file shifts one column per four steps, and the final column of a block is stored together with the transpose. Row results are loaded in parallel into a 4-stage output shift chain. Loading the next block therefore overlaps the row pass and the unloading of the previous one, and a new block starts every 16 steps.

Both edges are valid/ready streams. The whole pipeline advances one step at a time. A step happens when the input side can supply the next sample, or when a block boundary allows an internal empty block. A step also needs the output head to be free or taken in the same cycle. `in_ready` does not depend on `in_valid`, and `out_valid` does not depend on `out_ready`. Once offered, a coefficient stays valid and unchanged until it is taken. A new block may start only at a 16-step boundary. While results are still in flight and no input is offered at a boundary, the block inserts an empty block internally so that earlier results drain without further input.

Top module: `dct4x4_stream`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `out_first` are 0 and `in_ready` is 1.
- R2: For each block, the 16 coefficients equal K·B·Kᵀ. The input order is column-major: sample k is B[k mod 4][k div 4]. The output order is row-major: coefficient m is Y[m div 4][m mod 4]. `out_data` is two's complement.
- R3: `out_first` is 1 on Y[0][0] of every block and 0 on the other 15 coefficients. It is never 1 while `out_valid` is 0.
- R4: With `in_valid` and `out_ready` held at 1, consecutive blocks are accepted with no cycle of `in_ready` low, so one block is taken every 16 cycles.
- R5: With no stall, Y[0][0] is first offered on `out_valid` 17 clock edges after the edge that accepts the block's first sample.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_first` hold their values into the next cycle.
- R7: Cycles with `in_valid` low inside a block, and cycles of output back-pressure, pause the computation without changing any coefficient or its order.
- R8: After the last block's final sample is accepted, all of its coefficients are delivered with `in_valid` held at 0.
- R9: A new block starts only at a 16-step boundary. If the input pauses for one cycle at a boundary while results are in flight, a sample offered on the next cycle waits exactly 15 cycles with `in_ready` low.
- R10: For W_IN-bit inputs every coefficient lies within ±18·(2^W_IN−1). The all-maximum block gives Y[0][0] = 16·(2^W_IN−1), and the block that is maximal where row half and column half agree gives Y[1][1] = 18·(2^W_IN−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block accepts the offered sample this cycle |
| in_data | input | W_IN | Unsigned input sample |
| out_valid | output | 1 | Coefficient offered |
| out_ready | input | 1 | Consumer takes the offered coefficient |
| out_data | output | W_IN+7 | Signed coefficient |
| out_first | output | 1 | Marks Y[0][0] of a block |

## Verification
An asymmetric ramp block separates column-major from row-major input handling and exposes any swapped rows or columns of the kernel. It also gives the exact latency from idle. Constant-maximum blocks and the block that is maximal where the halves agree drive the DC term and the largest mixed term to their bounds, which catches width truncation. Random blocks sent back-to-back show the overlap of loading and unloading. Random blocks with input gaps and random back-pressure show that stalls change neither values nor order. A paused boundary followed by a new block separates correct block-boundary gating from early acceptance.

// File: rtl/dct4_pkg.sv
`timescale 1ns/1ps
package dct4_pkg;
  // transform size and the bit growth of one butterfly pass (gain at most 6 < 2^3)
  localparam int DCT_N       = 4;
  localparam int PASS_GROWTH = 3;
  localparam int PH_W        = $clog2(DCT_N * DCT_N);
endpackage

// File: rtl/dct4_kernel.sv
`timescale 1ns/1ps
// 4-point integer butterfly, rows [1 1 1 1] [2 1 -1 -2] [1 -1 -1 1] [1 -2 2 -1]
module dct4_kernel #(
  parameter int W_I = 12,
  parameter int W_O = 15
) (
  input  logic signed [W_I-1:0] x [4],
  output logic signed [W_O-1:0] y [4]
);
  logic signed [W_O-1:0] e [4];
  logic signed [W_O-1:0] s0, s1, d0, d1;

  always_comb begin
    for (int i = 0; i < 4; i++) e[i] = W_O'(x[i]);
    s0 = e[0] + e[3];
    s1 = e[1] + e[2];
    d0 = e[0] - e[3];
    d1 = e[1] - e[2];
    y[0] = s0 + s1;
    y[1] = (d0 <<< 1) + d1;
    y[2] = s0 - s1;
    y[3] = d0 - (d1 <<< 1);
  end
endmodule

// File: rtl/dct4_seq.sv
`timescale 1ns/1ps
// step sequencer: 16-step block phase, real/empty block tracking, stream gating
module dct4_seq
  import dct4_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            out_ready,
  input  logic            head_full,
  output logic            step,
  output logic            in_ready,
  output logic [PH_W-1:0] phase,
  output logic            tr_real
);
  logic ld_real;
  logic at_start, out_ok, adv;

  always_comb begin
    at_start = (phase == '0);
    out_ok   = !head_full || out_ready;
    if (at_start)     adv = in_valid || ld_real || tr_real;
    else if (ld_real) adv = in_valid;
    else              adv = 1'b1;
    step     = adv && out_ok;
    in_ready = out_ok && (at_start || ld_real);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      ld_real <= 1'b0;
      tr_real <= 1'b0;
    end else if (step) begin
      phase <= phase + 1'b1;
      if (at_start) begin
        ld_real <= in_valid;
        tr_real <= ld_real;
      end
    end
  end
endmodule

// File: rtl/dct4x4_stream.sv
`timescale 1ns/1ps
module dct4x4_stream
  import dct4_pkg::*;
#(
  parameter int W_IN = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [W_IN-1:0]               in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic signed [W_IN+2*PASS_GROWTH:0] out_data,
  output logic                          out_first
);
  localparam int N     = DCT_N;
  localparam int W_MID = W_IN + 1 + PASS_GROWTH;
  localparam int W_OUT = W_MID + PASS_GROWTH;

  logic            step, tr_real;
  logic [PH_W-1:0] phase;
  logic            blk_edge, col_op, row_op;

  logic [W_IN-1:0]         dsr [N];       // input column shift register
  logic signed [W_MID-1:0] tb  [N][N];    // transposition file, [column][element]
  logic signed [W_OUT-1:0] osr [N];       // output shift chain
  logic [N-1:0]            ovl, ofl;      // per-stage valid and block-start flags

  logic signed [W_MID-1:0] kx [N];
  logic signed [W_OUT-1:0] ky [N];
  logic signed [W_MID-1:0] ky_mid [N];

  dct4_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .head_full (ovl[0]),
    .step      (step),
    .in_ready  (in_ready),
    .phase     (phase),
    .tr_real   (tr_real)
  );

  assign blk_edge = (phase == '0);
  assign col_op   = (phase[1:0] == 2'd0);
  assign row_op   = (phase[1:0] == 2'd1);

  // shared kernel: column pass on the loaded column, row pass on the head buffer column
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (row_op) kx[i] = tb[0][i];
      else        kx[i] = signed'({{(W_MID-W_IN){1'b0}}, dsr[N-1-i]});
    end
  end

  dct4_kernel #(.W_I(W_MID), .W_O(W_OUT)) u_kernel (.x(kx), .y(ky));

  generate
    for (genvar g = 0; g < N; g++) begin : g_trunc
      assign ky_mid[g] = ky[g][W_MID-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (step) begin
      dsr[0] <= in_data;
      for (int i = 1; i < N; i++) dsr[i] <= dsr[i-1];

      if (blk_edge) begin
        // final column store fused with the transpose
        for (int i = 0; i < N; i++) begin
          for (int j = 0; j < N-1; j++) tb[i][j] <= tb[j+1][i];
          tb[i][N-1] <= ky_mid[i];
        end
      end else if (col_op) begin
        for (int c = 0; c < N-1; c++) tb[c] <= tb[c+1];
        tb[N-1] <= ky_mid;
      end

      if (row_op) begin
        osr <= ky;
      end else begin
        for (int i = 0; i < N-1; i++) osr[i] <= osr[i+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovl <= '0;
      ofl <= '0;
    end else if (step) begin
      if (row_op) begin
        ovl <= {N{tr_real}};
        ofl <= {{(N-1){1'b0}}, tr_real && (phase == PH_W'(1))};
      end else begin
        ovl <= {1'b0, ovl[N-1:1]};
        ofl <= {1'b0, ofl[N-1:1]};
      end
    end else if (ovl[0] && out_ready) begin
      ovl[0] <= 1'b0;
      ofl[0] <= 1'b0;
    end
  end

  assign out_valid = ovl[0];
  assign out_first = ofl[0];
  assign out_data  = osr[0];
endmodule

// File: rtl/dct4x4_stream_chk.sv
`timescale 1ns/1ps
module dct4x4_stream_chk #(
  parameter int W_IN  = 8,
  parameter int W_OUT = 15,
  parameter int PH_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [W_OUT-1:0] out_data,
  input logic                    out_first,
  input logic [PH_W-1:0]         phase
);
  localparam int LIM = 18 * ((1 << W_IN) - 1);

  logic [3:0] xfer_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                      xfer_cnt <= '0;
    else if (out_valid && out_ready) xfer_cnt <= xfer_cnt + 1'b1;
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_first)));

  assert_first_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);

  assert_block_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (out_first == (xfer_cnt == 4'd0)));

  assert_accept_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (phase == $past(phase) + 1'b1));

  assert_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_data) <= LIM && int'(out_data) >= -LIM));
endmodule

bind dct4x4_stream dct4x4_stream_chk #(
  .W_IN(W_IN), .W_OUT(W_OUT), .PH_W(dct4_pkg::PH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_first(out_first), .phase(phase)
);

// File: tb/sim_dct4x4_stream.sv
`timescale 1ns/1ps
module sim_dct4x4_stream;
  localparam int W_IN  = 8;
  localparam int W_OUT = W_IN + 7;
  localparam int MAXV  = (1 << W_IN) - 1;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ready, out_valid, out_ready, out_first;
  logic [W_IN-1:0] in_data;
  logic signed [W_OUT-1:0] out_data;

  always #2.5 clk = ~clk;

  dct4x4_stream #(.W_IN(W_IN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  int exp_q[$];
  bit expf_q[$];
  string cur_tag = "R2";
  int rmode = 0;
  bit gaps = 0;
  int bb [4][4];
  int cf [4][4] = '{'{1,1,1,1}, '{2,1,-1,-2}, '{1,-1,-1,1}, '{1,-2,2,-1}};
  int first_wait, all_wait, lat_start;
  bit lat_arm = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic fill(int pat);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        case (pat)
          0: bb[r][c] = (c * 4 + r) * 15 + r;
          1: bb[r][c] = MAXV;
          2: bb[r][c] = ((r < 2) == (c < 2)) ? MAXV : 0;
          default: bb[r][c] = int'($urandom_range(0, MAXV));
        endcase
  endtask

  task automatic send_block();
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++) begin
        int acc = 0;
        for (int r = 0; r < 4; r++)
          for (int c = 0; c < 4; c++)
            acc += cf[i][r] * bb[r][c] * cf[k][c];
        exp_q.push_back(acc);
        expf_q.push_back(i == 0 && k == 0);
      end
    first_wait = 0;
    for (int s = 0; s < 16; s++) begin
      if (gaps && $urandom_range(0, 3) == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = W_IN'(bb[s % 4][s / 4]);
      while (!in_ready) begin
        if (s == 0) first_wait++;
        all_wait++;
        @(negedge clk);
      end
      if (s == 0) lat_start = cyc;
    end
  endtask

  task automatic idle_in(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    idle_in(40);
  endtask

  task automatic monitor();
    int held = 0;
    bit hold_pending = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_pending) begin
          chk(out_valid && int'(out_data) == held, "R6", int'(out_data), held);
          hold_pending = 0;
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, cur_tag, int'(out_data), -1);
          end else begin
            int e = exp_q.pop_front();
            bit f = expf_q.pop_front();
            chk(int'(out_data) == e, cur_tag, int'(out_data), e);
            chk(out_first == f, "R3", int'(out_first), int'(f));
            if (f && lat_arm) begin
              chk(cyc - lat_start == 18, "R5", cyc - lat_start, 18);
              lat_arm = 0;
            end
          end
        end else if (out_valid) begin
          held = int'(out_data);
          hold_pending = 1;
        end
      end
    end
  endtask

  task automatic ready_gen();
    forever begin
      @(posedge clk);
      #1;
      out_ready = (rmode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
    end
  endtask

  task automatic watchdog();
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    fork
      monitor();
      ready_gen();
      watchdog();
    join_none
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_first == 1'b0, "R1", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", int'(out_valid), 0);

    // ramp from idle: ordering, latency, flush
    cur_tag = "R2"; lat_arm = 1; fill(0); send_block();
    idle_in(1);
    cur_tag = "R8"; drain("R8");

    // extremes
    cur_tag = "R10"; fill(1); send_block(); fill(2); send_block();
    idle_in(1); drain("R10");

    // back-to-back random blocks, no stalls expected
    cur_tag = "R4"; all_wait = 0;
    for (int b = 0; b < 4; b++) begin fill(3); send_block(); end
    chk(all_wait == 0, "R4", all_wait, 0);
    idle_in(1); drain("R4");

    // boundary gating after a one-cycle pause
    cur_tag = "R9"; fill(3); send_block(); idle_in(1);
    fill(0); send_block();
    chk(first_wait == 15, "R9", first_wait, 15);
    idle_in(1); drain("R9");

    // input gaps and output back-pressure
    cur_tag = "R7"; gaps = 1; rmode = 1;
    for (int b = 0; b < 6; b++) begin fill(b == 0 ? 0 : 3); send_block(); end
    idle_in(1); drain("R7");
    gaps = 0; rmode = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule